// File: doc/BRIEF.md
# Expression stack with register spill

This block is the operand stack of a zero-address arithmetic engine. The shallowest `REG_SLOTS` entries sit in a shifting register file, where the arithmetic unit reads them directly. Deeper entries live in an external backing memory that grows upward from address 0. Commands come in over a valid/ready channel. They push a data word, pop the top entry, or combine the top two entries with add, subtract, multiply or divide. The block writes the deepest register entry to memory only when a push finds every register occupied. It reads one entry back only when a pop or an operation leaves a register free while memory still holds data. It never touches memory on other commands.

A small state machine sequences the memory traffic. In `IDLE` it accepts commands. The transition `IDLE -> SPILL` is taken on a push into full registers, and the transition `IDLE -> FILL` on a pop or operation while memory is occupied. The transitions `SPILL -> IDLE` and `FILL -> IDLE` are taken on the cycle the memory acknowledges. Commands stall while the machine is in `SPILL` or `FILL`. The block reports the top-of-stack value, running counts of spills and fills, single-cycle underflow and overflow error pulses, and a sticky divide-by-zero flag.

Top module: `expr_stack_spill`

## Requirements
- R1: After reset, `tos_valid` and `tos_data` are 0, `cmd_ready` is 1, `mem_req` is 0, both counters are 0 and all error outputs are 0.
- R2: Command codes are: push = 0, pop = 1, add = 2, sub = 3, mul = 4, div = 5. A push makes `cmd_data` the new top. A pop exposes the entry beneath. The stack behaves last-in first-out across the register and memory portions.
- R3: A binary command removes the top two entries and pushes one result. The entry under the top is the left operand, so subtract gives second minus top and divide gives second / top (unsigned). Add, subtract and multiply keep the low `DATA_W` bits.
- R4: A push while all `REG_SLOTS` registers are occupied writes the deepest register entry to memory at address equal to the number of entries already in memory, and increments `spill_count` once on acknowledge. No other command writes memory.
- R5: A pop or binary command while memory holds entries reads address (memory entries - 1) into the deepest register slot and increments `fill_count` once on acknowledge. No other command reads memory.
- R6: With `REG_SLOTS` = 2 and an empty stack, the sequence a b c * + a d c * + e - / yields exactly 4 spills, 4 fills and the value (a + b*c) / (a + d*c - e).
- R7: `cmd_ready` is 0 from the cycle after accepting a command that needs memory until the cycle after `mem_ack`. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until acknowledged. `cmd_ready` stays 1 after a command that needs no memory.
- R8: A pop on an empty stack, or a binary command with fewer than two entries, pulses `err_underflow` for one cycle and changes no state.
- R9: A push with all registers full and `MEM_SLOTS` entries in memory pulses `err_overflow` for one cycle, drops the value and issues no memory access.
- R10: Divide by zero produces all ones and sets `err_div0`, which stays set until reset.
- R11: Codes 6 and 7 are accepted and have no effect on the stack, the counters or the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with `cmd_valid` |
| cmd_op | input | 3 | Command code |
| cmd_data | input | DATA_W | Value for push |
| mem_req | output | 1 | Memory access outstanding |
| mem_we | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr | output | clog2(MEM_SLOTS) | Memory word address |
| mem_wdata | output | DATA_W | Spilled value |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ack` |
| tos_data | output | DATA_W | Current top entry, 0 when empty |
| tos_valid | output | 1 | Stack is not empty |
| spill_count | output | CNT_W | Completed spills |
| fill_count | output | CNT_W | Completed fills |
| err_underflow | output | 1 | One-cycle pulse: too few entries |
| err_overflow | output | 1 | One-cycle pulse: memory full on spill |
| err_div0 | output | 1 | Sticky divide-by-zero flag |

## Verification
A wrong register occupancy count shows at the ports within one command. It either raises a spurious or missing underflow pulse, or starts or skips a memory access, which moves `cmd_ready` and a counter on the next cycle. A wrong memory entry count surfaces as a wrong `mem_addr` on the next spill or fill. The misplaced data then reaches `tos_data` only when that entry is popped back, which can be many commands later, so the stack is repeatedly driven deep and drained again in last-in first-out order. A misordered shift in the register file shows directly on `tos_data` after the next pop or operation.

// File: rtl/expr_stack_pkg.sv
package expr_stack_pkg;

    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_MUL  = 3'd4,
        OP_DIV  = 3'd5
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SPILL = 2'd1,
        ST_FILL  = 2'd2
    } stk_state_e;

    // Register-file action chosen by the controller for the coming edge
    typedef enum logic [2:0] {
        RF_HOLD  = 3'd0,
        RF_PUSH  = 3'd1,
        RF_POP   = 3'd2,
        RF_BINOP = 3'd3,
        RF_FILL  = 3'd4
    } rf_act_e;

endpackage

// File: rtl/stack_alu.sv
module stack_alu #(
    parameter int DATA_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] result,
    output logic              div_zero
);
    import expr_stack_pkg::*;

    assign div_zero = (rhs == '0);

    always_comb begin
        unique case (op)
            OP_ADD:  result = lhs + rhs;
            OP_SUB:  result = lhs - rhs;
            OP_MUL:  result = lhs * rhs;
            OP_DIV:  result = div_zero ? '1 : lhs / rhs;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/stack_regfile.sv
module stack_regfile #(
    parameter int DATA_W    = 16,
    parameter int REG_SLOTS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  expr_stack_pkg::rf_act_e  act,
    input  logic [DATA_W-1:0]        push_data,
    input  logic [DATA_W-1:0]        op_result,
    input  logic [DATA_W-1:0]        fill_data,
    output logic [DATA_W-1:0]        top_q,
    output logic [DATA_W-1:0]        second_q,
    output logic [DATA_W-1:0]        deep_q
);
    import expr_stack_pkg::*;

    // Slot 0 is the top of stack; slot REG_SLOTS-1 is the deepest register
    logic [DATA_W-1:0] slot_q  [REG_SLOTS];
    logic [DATA_W-1:0] shallower [REG_SLOTS];
    logic [DATA_W-1:0] deeper    [REG_SLOTS];

    for (genvar i = 0; i < REG_SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_first
            assign shallower[i] = push_data;
        end else begin : g_inner
            assign shallower[i] = slot_q[i-1];
        end

        if (i == REG_SLOTS - 1) begin : g_last
            assign deeper[i] = '0;
        end else begin : g_mid
            assign deeper[i] = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                unique case (act)
                    RF_PUSH:  slot_q[i] <= shallower[i];
                    RF_POP:   slot_q[i] <= deeper[i];
                    RF_BINOP: slot_q[i] <= (i == 0) ? op_result : deeper[i];
                    RF_FILL:  if (i == REG_SLOTS - 1) slot_q[i] <= fill_data;
                    default:  ;
                endcase
            end
        end
    end

    assign top_q    = slot_q[0];
    assign second_q = slot_q[1];
    assign deep_q   = slot_q[REG_SLOTS-1];

endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl #(
    parameter int DATA_W    = 16,
    parameter int REG_SLOTS = 2,
    parameter int MEM_SLOTS = 64,
    parameter int CNT_W     = 16,
    localparam int AW  = $clog2(MEM_SLOTS),
    localparam int MCW = $clog2(MEM_SLOTS + 1),
    localparam int RCW = $clog2(REG_SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [DATA_W-1:0]       deep_entry,
    input  logic                    div_zero,
    input  logic                    mem_ack,
    output logic                    cmd_ready,
    output expr_stack_pkg::rf_act_e rf_act,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [AW-1:0]           mem_addr,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    tos_valid,
    output logic [CNT_W-1:0]        spill_count,
    output logic [CNT_W-1:0]        fill_count,
    output logic                    err_underflow,
    output logic                    err_overflow,
    output logic                    err_div0
);
    import expr_stack_pkg::*;

    stk_state_e        state_q, state_d;
    logic [RCW-1:0]    reg_cnt;
    logic [MCW-1:0]    mem_cnt;
    logic [DATA_W-1:0] spill_q;

    logic accept, is_push, is_pop, is_bin;
    logic regs_full, mem_full, mem_some;
    logic under, over;
    logic do_push, do_pop, do_bin;
    logic need_spill, need_fill;

    // Command decode
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign is_push   = (cmd_op == OP_PUSH);
    assign is_pop    = (cmd_op == OP_POP);
    assign is_bin    = (cmd_op >= OP_ADD) && (cmd_op <= OP_DIV);
    assign regs_full = (reg_cnt == RCW'(REG_SLOTS));
    assign mem_full  = (mem_cnt == MCW'(MEM_SLOTS));
    assign mem_some  = (mem_cnt != '0);

    // Memory is occupied only when every register is, so the register
    // count alone decides whether one or two entries exist.
    assign under = accept && ((is_pop && reg_cnt == '0) ||
                              (is_bin && reg_cnt < RCW'(2)));
    assign over  = accept && is_push && regs_full && mem_full;

    assign do_push    = accept && is_push && !over;
    assign do_pop     = accept && is_pop  && !under;
    assign do_bin     = accept && is_bin  && !under;
    assign need_spill = do_push && regs_full;
    assign need_fill  = (do_pop || do_bin) && mem_some;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        rf_act    = RF_HOLD;
        cmd_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (do_push)     rf_act = RF_PUSH;
                else if (do_pop) rf_act = RF_POP;
                else if (do_bin) rf_act = RF_BINOP;
                if (need_spill)     state_d = ST_SPILL;
                else if (need_fill) state_d = ST_FILL;
            end
            ST_SPILL: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) state_d = ST_IDLE;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    rf_act  = RF_FILL;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_addr  = (state_q == ST_FILL) ? mem_cnt[AW-1:0] - AW'(1)
                                            : mem_cnt[AW-1:0];
    assign mem_wdata = spill_q;
    assign tos_valid = (reg_cnt != '0);

    // Occupancy, spill holding register, counters and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_cnt       <= '0;
            mem_cnt       <= '0;
            spill_q       <= '0;
            spill_count   <= '0;
            fill_count    <= '0;
            err_underflow <= 1'b0;
            err_overflow  <= 1'b0;
            err_div0      <= 1'b0;
        end else begin
            err_underflow <= under;
            err_overflow  <= over;
            if (do_bin && cmd_op == OP_DIV && div_zero) err_div0 <= 1'b1;

            if (need_spill) spill_q <= deep_entry;

            if (rf_act == RF_PUSH && !regs_full)                reg_cnt <= reg_cnt + RCW'(1);
            else if (rf_act == RF_POP || rf_act == RF_BINOP)    reg_cnt <= reg_cnt - RCW'(1);
            else if (rf_act == RF_FILL)                         reg_cnt <= reg_cnt + RCW'(1);

            if (state_q == ST_SPILL && mem_ack) begin
                mem_cnt     <= mem_cnt + MCW'(1);
                spill_count <= spill_count + CNT_W'(1);
            end else if (state_q == ST_FILL && mem_ack) begin
                mem_cnt     <= mem_cnt - MCW'(1);
                fill_count  <= fill_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/expr_stack_spill.sv
module expr_stack_spill #(
    parameter int DATA_W    = 16,
    parameter int REG_SLOTS = 2,
    parameter int MEM_SLOTS = 64,
    parameter int CNT_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    output logic                         cmd_ready,
    input  logic [2:0]                   cmd_op,
    input  logic [DATA_W-1:0]            cmd_data,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [$clog2(MEM_SLOTS)-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic                         mem_ack,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic [DATA_W-1:0]            tos_data,
    output logic                         tos_valid,
    output logic [CNT_W-1:0]             spill_count,
    output logic [CNT_W-1:0]             fill_count,
    output logic                         err_underflow,
    output logic                         err_overflow,
    output logic                         err_div0
);
    import expr_stack_pkg::*;

    rf_act_e           rf_act;
    logic [DATA_W-1:0] top_q, second_q, deep_q, alu_res;
    logic              div_zero;

    stack_ctrl #(
        .DATA_W(DATA_W), .REG_SLOTS(REG_SLOTS),
        .MEM_SLOTS(MEM_SLOTS), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .deep_entry(deep_q), .div_zero(div_zero), .mem_ack(mem_ack),
        .cmd_ready(cmd_ready), .rf_act(rf_act),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .tos_valid(tos_valid),
        .spill_count(spill_count), .fill_count(fill_count),
        .err_underflow(err_underflow), .err_overflow(err_overflow),
        .err_div0(err_div0)
    );

    stack_regfile #(
        .DATA_W(DATA_W), .REG_SLOTS(REG_SLOTS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .act(rf_act),
        .push_data(cmd_data), .op_result(alu_res), .fill_data(mem_rdata),
        .top_q(top_q), .second_q(second_q), .deep_q(deep_q)
    );

    stack_alu #(
        .DATA_W(DATA_W)
    ) u_alu (
        .op(cmd_op), .lhs(second_q), .rhs(top_q),
        .result(alu_res), .div_zero(div_zero)
    );

    assign tos_data = tos_valid ? top_q : '0;

endmodule

// File: rtl/expr_stack_spill_chk.sv
module expr_stack_spill_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] tos_data,
    input logic [CNT_W-1:0]  spill_count,
    input logic [CNT_W-1:0]  fill_count,
    input logic              err_underflow,
    input logic              err_overflow,
    input logic              err_div0
);

    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) &&
                                $stable(mem_addr) && $stable(mem_wdata));

    a_r7_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> cmd_ready && !mem_req);

    a_r4_spill_counted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> (spill_count - $past(spill_count)) == CNT_W'(1));

    a_r4_spill_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_we && mem_ack) |=> $stable(spill_count));

    a_r5_fill_counted: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=> (fill_count - $past(fill_count)) == CNT_W'(1));

    a_r5_fill_only_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && !mem_we && mem_ack) |=> $stable(fill_count));

    a_r8_underflow_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> $stable(tos_data) && !mem_req);

    a_r9_overflow_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $stable(tos_data) && !mem_req);

    a_r10_div0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_div0 |=> err_div0);

endmodule

bind expr_stack_spill expr_stack_spill_chk #(
    .DATA_W(DATA_W), .ADDR_W($clog2(MEM_SLOTS)), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tos_data(tos_data),
    .spill_count(spill_count), .fill_count(fill_count),
    .err_underflow(err_underflow), .err_overflow(err_overflow),
    .err_div0(err_div0)
);

// File: tb/test_expr_stack_spill.sv
`timescale 1ns/1ps
module test_expr_stack_spill;

    localparam int N  = 2;
    localparam int MD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        mem_req, mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic [15:0] tos_data;
    logic        tos_valid;
    logic [15:0] spill_count, fill_count;
    logic        err_underflow, err_overflow, err_div0;

    expr_stack_spill i_expr_stack_spill (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .tos_data(tos_data), .tos_valid(tos_valid),
        .spill_count(spill_count), .fill_count(fill_count),
        .err_underflow(err_underflow), .err_overflow(err_overflow),
        .err_div0(err_div0)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int acks   = 0;
    logic [15:0] bmem [0:MD-1];

    // Reference model of the whole stack
    logic [15:0] mdl [0:127];
    int depth = 0;
    int exp_spill = 0;
    int exp_fill = 0;
    bit exp_div0 = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act %0h exp %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_op(input logic [2:0] op,
                                           input logic [15:0] a, input logic [15:0] b);
        case (op)
            3'd2:    return a + b;
            3'd3:    return a - b;
            3'd4:    return a * b;
            3'd5:    return (b == 16'd0) ? 16'hFFFF : a / b;
            default: return 16'd0;
        endcase
    endfunction

    // Memory responder with random acknowledge latency
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req) begin
                if (lat == 0) begin
                    mem_ack = 1'b1;
                    acks++;
                    if (mem_we) bmem[mem_addr] = mem_wdata;
                    else        mem_rdata = bmem[mem_addr];
                    lat = $urandom_range(0, 2);
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic exec(input logic [2:0] op, input logic [15:0] d);
        bit got_uf, got_of, got_stall;
        bit is_bin, e_uf, e_of, e_stall;
        string tag;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        got_uf = err_underflow; got_of = err_overflow; got_stall = !cmd_ready;
        while (!cmd_ready) @(negedge clk);

        is_bin  = (op >= 3'd2) && (op <= 3'd5);
        e_uf    = (op == 3'd1 && depth < 1) || (is_bin && depth < 2);
        e_of    = (op == 3'd0) && depth >= N && (depth - N) == MD;
        e_stall = !e_uf && !e_of &&
                  ((op == 3'd0 && depth >= N) || ((op == 3'd1 || is_bin) && depth > N));
        tag = (op == 3'd0 || op == 3'd1) ? "R2" : (is_bin ? "R3" : "R11");
        if (e_uf) tag = "R8";
        if (e_of) tag = "R9";

        if (!e_uf && !e_of) begin
            if (op == 3'd0) begin
                if (depth >= N) exp_spill++;
                mdl[depth] = d; depth++;
            end else if (op == 3'd1) begin
                if (depth > N) exp_fill++;
                depth--;
            end else if (is_bin) begin
                if (depth > N) exp_fill++;
                if (op == 3'd5 && mdl[depth-1] == 16'd0) exp_div0 = 1;
                mdl[depth-2] = ref_op(op, mdl[depth-2], mdl[depth-1]);
                depth--;
            end
        end

        chk(tos_data == ((depth > 0) ? mdl[depth-1] : 16'd0), tag, "tos_data",
            tos_data, (depth > 0) ? mdl[depth-1] : 16'd0);
        chk(tos_valid == (depth > 0), tag, "tos_valid", tos_valid, depth > 0);
        chk(spill_count == exp_spill[15:0], "R4", "spill_count", spill_count, exp_spill);
        chk(fill_count == exp_fill[15:0], "R5", "fill_count", fill_count, exp_fill);
        chk(got_uf == e_uf, "R8", "err_underflow", got_uf, e_uf);
        chk(got_of == e_of, "R9", "err_overflow", got_of, e_of);
        chk(err_div0 == exp_div0, "R10", "err_div0", err_div0, exp_div0);
        chk(got_stall == e_stall, "R7", "stall", got_stall, e_stall);
    endtask

    task automatic drain();
        while (depth > 0) exec(3'd1, 16'd0);
    endtask

    initial begin
        int s0, f0, a0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tos_valid == 1'b0 && tos_data == 16'd0, "R1", "tos after reset", tos_data, 0);
        chk(cmd_ready == 1'b1 && mem_req == 1'b0, "R1", "ready/req after reset",
            {cmd_ready, mem_req}, 2'b10);
        chk(spill_count == 0 && fill_count == 0, "R1", "counters after reset",
            {spill_count, fill_count}, 0);
        chk({err_underflow, err_overflow, err_div0} == 3'b000, "R1", "errors after reset",
            {err_underflow, err_overflow, err_div0}, 0);

        // R8 underflow cases
        exec(3'd1, 16'd0);
        exec(3'd0, 16'd5);
        exec(3'd2, 16'd0);
        chk(tos_data == 16'd5, "R8", "top kept after underflow", tos_data, 5);
        drain();

        // R4 spill content and address, R5 fill
        exec(3'd0, 16'd10); exec(3'd0, 16'd11); exec(3'd0, 16'd12);
        chk(bmem[0] == 16'd10, "R4", "spilled word at address 0", bmem[0], 10);
        exec(3'd0, 16'd13);
        chk(bmem[1] == 16'd11, "R4", "spilled word at address 1", bmem[1], 11);
        exec(3'd1, 16'd0);
        exec(3'd1, 16'd0);
        chk(tos_data == 16'd11, "R5", "refilled order", tos_data, 11);
        drain();

        // R3 operand order
        exec(3'd0, 16'd9); exec(3'd0, 16'd4); exec(3'd3, 16'd0);
        chk(tos_data == 16'd5, "R3", "9-4", tos_data, 5);
        exec(3'd0, 16'd4); exec(3'd0, 16'd9); exec(3'd3, 16'd0);
        chk(tos_data == 16'hFFFB, "R3", "4-9 wraps", tos_data, 16'hFFFB);
        exec(3'd0, 16'd20); exec(3'd0, 16'd6); exec(3'd5, 16'd0);
        chk(tos_data == 16'd3, "R3", "20/6", tos_data, 3);
        drain();

        // R11 ignored codes
        exec(3'd0, 16'd77);
        a0 = acks;
        exec(3'd6, 16'd1); exec(3'd7, 16'd2);
        chk(tos_data == 16'd77 && acks == a0, "R11", "ignored codes", tos_data, 77);
        drain();

        // R6 expression a b c * + a d c * + e - /
        s0 = spill_count; f0 = fill_count;
        exec(3'd0, 16'd200); exec(3'd0, 16'd30); exec(3'd0, 16'd10); exec(3'd4, 16'd0);
        exec(3'd2, 16'd0);
        exec(3'd0, 16'd200); exec(3'd0, 16'd4); exec(3'd0, 16'd10); exec(3'd4, 16'd0);
        exec(3'd2, 16'd0);
        exec(3'd0, 16'd40); exec(3'd3, 16'd0); exec(3'd5, 16'd0);
        chk(spill_count - s0 == 4, "R6", "spills", spill_count - s0, 4);
        chk(fill_count - f0 == 4, "R6", "fills", fill_count - f0, 4);
        chk(tos_data == 16'd2 && depth == 1, "R6", "result", tos_data, 2);
        drain();

        // R10 divide by zero
        exec(3'd0, 16'd7); exec(3'd0, 16'd0); exec(3'd5, 16'd0);
        chk(tos_data == 16'hFFFF, "R10", "div by zero value", tos_data, 16'hFFFF);
        chk(err_div0 == 1'b1, "R10", "sticky flag", err_div0, 1);
        drain();

        // R9 overflow at full depth, then LIFO drain through memory
        for (int i = 0; i < N + MD; i++) exec(3'd0, 16'(i + 100));
        a0 = acks;
        exec(3'd0, 16'hBEEF);
        chk(acks == a0 && tos_data == 16'(N + MD - 1 + 100), "R9", "push dropped",
            tos_data, N + MD - 1 + 100);
        drain();

        // Random mix
        for (int k = 0; k < 500; k++) begin
            int r = $urandom_range(0, 99);
            logic [15:0] v = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 3))
                                                         : 16'($urandom);
            if (r < 45 && depth < 40)  exec(3'd0, v);
            else if (r < 65)           exec(3'd1, 16'd0);
            else if (r < 95)           exec(3'(2 + (r % 4)), 16'd0);
            else                       exec(3'(6 + (r % 2)), v);
        end
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog act hung exp done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule